// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides its input clock by an integer that software sets through a 32-bit control word. One bit field of that word, whose offset and width are parameters, holds the ratio code. A parameter picks one of five encodings that turn the code into a divisor: the code plus one, the raw code with zero illegal, the raw code with zero meaning pass-through, two to the power of the code, or the raw code with zero meaning two to the power of the field width.

The block has two outputs. A one-cycle `tick` marks the first input cycle of every output period. `clk_out` is a square wave that is high for the first half of each period; when the period is odd, the high half is one cycle shorter. A divisor of one sends the input clock straight through to `clk_out`.

A newly written ratio never cuts a period short. It waits for the period in progress to finish and is applied on the period boundary. Two build options change how writes behave. With masked writes, the upper half of each write selects which bits of the lower half change. With the read-only option, the ratio stays at its reset setting for good. An illegal zero divisor stops the output, holding it low, and sets a sticky error flag.

Top module: `clkdiv_top`

## Requirements
- R1: In plus-one encoding the divisor is the field value plus one, so `tick` repeats every field+1 input cycles.
- R2: In raw encoding the divisor is the field value. A zero field, once applied, holds `tick` and `clk_out` low and sets `err`.
- R3: In pass-through encoding a zero field gives divisor one. `clk_out` then follows the input clock and `tick` is high on every cycle.
- R4: In power encoding the divisor is 2 raised to the field value.
- R5: In top-at-zero encoding a nonzero field is the divisor and a zero field means 2^FIELD_W.
- R6: For any divisor D ≥ 2, `clk_out` is high for the first floor(D/2) cycles of each period, starting with the `tick` cycle, and low for the remaining cycles.
- R7: A changed field takes effect only after the current period completes. The next period then starts with a `tick` at the new length.
- R8: With masked writes, bit i (0..15) changes only if bit 16+i of the same write is 1. Bits 31:16 of `rd_data` always read 0.
- R9: Without masking or read-only, a write stores all 32 bits of `wr_data`, and `rd_data` returns them from the next cycle.
- R10: With read-only set, writes never change `rd_data`, which keeps RESET_VALUE.
- R11: `err` stays set until reset, even after a legal divisor is applied.
- R12: After reset, `rd_data` equals RESET_VALUE (masked to its low half when masking is on), `err` is clear unless the reset divisor is illegal, and a period starts, with `tick` high in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value (upper half is the bit mask when masking is on) |
| rd_data | output | 32 | Current control word |
| tick | output | 1 | High in the first input cycle of each output period |
| clk_out | output | 1 | Divided square wave, or the input clock when the divisor is one |
| err | output | 1 | Sticky flag for an applied zero divisor |

## Verification
The assertions assume that reset is held for at least two clock edges, so that their one-cycle look-back sees settled state. They also assume that write strobes and data change only away from the rising edge. The bench raises reset for three cycles and drives every input on the falling edge. With masking enabled, the field must lie in the lower 16 bits. Every configuration in the bench places a 4-bit field at bit 4. The write sequence changes ratios in the middle of a period, writes a zero field, and sends an empty mask, so that each encoding meets its zero case and a boundary-aligned change.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Encodings that turn the ratio field into an integer divisor
    typedef enum logic [2:0] {
        DM_PLUS_ONE    = 3'd0,
        DM_ONE_BASED   = 3'd1,
        DM_ZERO_BYPASS = 3'd2,
        DM_POW2        = 3'd3,
        DM_MAX_AT_ZERO = 3'd4
    } div_mode_e;

    // Divisor register width needed to hold the largest divisor of a mode
    function automatic int div_width(div_mode_e m, int w);
        return (m == DM_POW2) ? (1 << w) : (w + 1);
    endfunction

    // Lower-half update under an upper-half bit mask
    function automatic logic [31:0] masked_merge(logic [15:0] cur, logic [31:0] wd);
        logic [15:0] m;
        m = wd[31:16];
        return {16'h0000, (cur & ~m) | (wd[15:0] & m)};
    endfunction

endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
    import clkdiv_pkg::*;
#(
    parameter bit          MASKED    = 1'b0,
    parameter bit          READ_ONLY = 1'b0,
    parameter logic [31:0] RST_WORD  = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_q
);

    logic [31:0] next_word;

    generate
        if (MASKED) begin : g_masked
            assign next_word = masked_merge(ctrl_q[15:0], wr_data);
        end else begin : g_plain
            assign next_word = wr_data;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= RST_WORD;
        end else if (wr_en && !READ_ONLY) begin
            ctrl_q <= next_word;
        end
    end

endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
#(
    parameter div_mode_e MODE    = DM_PLUS_ONE,
    parameter int        FIELD_W = 4,
    parameter int        DIV_W   = FIELD_W + 1
) (
    input  logic [FIELD_W-1:0] field,
    output logic [DIV_W-1:0]   divisor
);

    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] wide;
    logic             is_zero;

    assign wide    = {{(DIV_W-FIELD_W){1'b0}}, field};
    assign is_zero = (field == '0);

    always_comb begin
        case (MODE)
            DM_PLUS_ONE:    divisor = wide + ONE;
            DM_ONE_BASED:   divisor = wide;
            DM_ZERO_BYPASS: divisor = is_zero ? ONE : wide;
            DM_POW2:        divisor = ONE << field;
            DM_MAX_AT_ZERO: divisor = is_zero ? (ONE << FIELD_W) : wide;
            default:        divisor = wide + ONE;
        endcase
    end

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] pend_div,
    input  logic [DIV_W-1:0] rst_div,
    output logic [DIV_W-1:0] act_div,
    output logic             phase_hi,
    output logic             tick,
    output logic             err
);

    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } period_t;

    period_t st_q, st_d;
    logic    hi_q, err_q;
    logic    at_end;

    // A zero divisor is treated as a permanent boundary so a legal value loads at once
    assign at_end = (st_q.div == '0) || (st_q.cnt == st_q.div - ONE);

    always_comb begin
        st_d = st_q;
        if (at_end) begin
            st_d.cnt = '0;
            st_d.div = pend_div;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{cnt: '0, div: rst_div};
            hi_q  <= ((rst_div >> 1) != '0);
            err_q <= (rst_div == '0);
        end else begin
            st_q  <= st_d;
            hi_q  <= ((st_d.div >> 1) > st_d.cnt);
            err_q <= err_q | (at_end && (pend_div == '0));
        end
    end

    assign act_div  = st_q.div;
    assign phase_hi = hi_q;
    assign err      = err_q;
    assign tick     = (st_q.div != '0) && (st_q.cnt == '0);

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter div_mode_e   MODE        = DM_PLUS_ONE,
    parameter int          FIELD_LSB   = 4,
    parameter int          FIELD_W     = 4,
    parameter bit          MASKED      = 1'b0,
    parameter bit          READ_ONLY   = 1'b0,
    parameter logic [31:0] RESET_VALUE = 32'h0000_0030
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        tick,
    output logic        clk_out,
    output logic        err
);

    localparam int          DIV_W    = div_width(MODE, FIELD_W);
    localparam logic [31:0] RST_WORD = MASKED ? {16'h0000, RESET_VALUE[15:0]} : RESET_VALUE;
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [31:0]      ctrl_q;
    logic [DIV_W-1:0] pend_div, rst_div, act_div;
    logic             phase_hi;

    clkdiv_ctrl_reg #(
        .MASKED   (MASKED),
        .READ_ONLY(READ_ONLY),
        .RST_WORD (RST_WORD)
    ) u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .ctrl_q (ctrl_q)
    );

    clkdiv_decode #(
        .MODE   (MODE),
        .FIELD_W(FIELD_W),
        .DIV_W  (DIV_W)
    ) u_dec_live (
        .field  (ctrl_q[FIELD_LSB +: FIELD_W]),
        .divisor(pend_div)
    );

    clkdiv_decode #(
        .MODE   (MODE),
        .FIELD_W(FIELD_W),
        .DIV_W  (DIV_W)
    ) u_dec_rst (
        .field  (RST_WORD[FIELD_LSB +: FIELD_W]),
        .divisor(rst_div)
    );

    clkdiv_core #(
        .DIV_W(DIV_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .pend_div(pend_div),
        .rst_div (rst_div),
        .act_div (act_div),
        .phase_hi(phase_hi),
        .tick    (tick),
        .err     (err)
    );

    assign rd_data = ctrl_q;
    assign clk_out = (act_div == ONE) ? clk : phase_hi;

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
    parameter int DIV_W     = 5,
    parameter bit MASKED    = 1'b0,
    parameter bit READ_ONLY = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [15:0]      wr_mask,
    input logic [31:0]      rd_data,
    input logic             tick,
    input logic             err,
    input logic [DIV_W-1:0] act_div,
    input logic             phase_hi
);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R10
    ro_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (READ_ONLY && wr_en) |=> $stable(rd_data));

    // R8
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (MASKED && wr_en && wr_mask == 16'h0) |=> $stable(rd_data));

    // R6
    tick_high_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && act_div > 1) |-> phase_hi);

    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && act_div > 1) |=> !tick);

    // R7
    load_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(act_div) && act_div != '0) |-> tick);

    // R2
    zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (act_div == '0) |-> (!tick && !phase_hi));

endmodule

bind clkdiv_top clkdiv_chk #(
    .DIV_W    (DIV_W),
    .MASKED   (MASKED),
    .READ_ONLY(READ_ONLY)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_mask (wr_data[31:16]),
    .rd_data (rd_data),
    .tick    (tick),
    .err     (err),
    .act_div (act_div),
    .phase_hi(phase_hi)
);

// File: tb/clkdiv_top_test.sv
`timescale 1ns/1ps

module clkdiv_ref
    import clkdiv_pkg::*;
#(
    parameter div_mode_e   MODE    = DM_PLUS_ONE,
    parameter int          LSB     = 4,
    parameter int          W       = 4,
    parameter bit          MASKED  = 1'b0,
    parameter bit          RO      = 1'b0,
    parameter logic [31:0] RV      = 32'h30,
    parameter string       DIV_TAG = "R1",
    parameter string       WR_TAG  = "R9",
    parameter string       ERR_TAG = "R11"
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic [31:0] rd_data,
    input  logic        tick,
    input  logic        clk_out,
    input  logic        err,
    output int          n_chk,
    output int          n_bad
);

    logic [31:0] regv;
    int          div, cnt;
    bit          m_err, live;

    function automatic int decode(logic [31:0] word);
        int f;
        f = int'((word >> LSB) & ((32'd1 << W) - 1));
        case (MODE)
            DM_PLUS_ONE:    return f + 1;
            DM_ONE_BASED:   return f;
            DM_ZERO_BYPASS: return (f == 0) ? 1 : f;
            DM_POW2:        return 1 << f;
            default:        return (f == 0) ? (1 << W) : f;
        endcase
    endfunction

    initial begin
        n_chk = 0;
        n_bad = 0;
        live  = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            regv  = MASKED ? {16'h0, RV[15:0]} : RV;
            div   = decode(regv);
            cnt   = 0;
            m_err = (div == 0);
            live  = 1;
        end else if (live) begin
            if (div == 0 || cnt == div - 1) begin
                div = decode(regv);
                cnt = 0;
                if (div == 0) m_err = 1;
            end else begin
                cnt = cnt + 1;
            end
            if (wr_en && !RO) begin
                if (MASKED) begin
                    for (int i = 0; i < 16; i++)
                        if (wr_data[16+i]) regv[i] = wr_data[i];
                    regv[31:16] = 16'h0;
                end else begin
                    regv = wr_data;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (live) begin
            #5;
            n_chk = n_chk + 4;
            if (rd_data !== regv) begin
                n_bad++;
                $display("FAIL %s rd_data got %h exp %h", WR_TAG, rd_data, regv);
            end
            // R7: the model only switches length at a period boundary
            if (tick !== (div != 0 && cnt == 0)) begin
                n_bad++;
                $display("FAIL %s/R7 tick got %b exp %b", DIV_TAG, tick, (div != 0 && cnt == 0));
            end
            if (clk_out !== (div >= 2 && cnt < div / 2)) begin
                n_bad++;
                $display("FAIL R6 clk_out got %b exp %b", clk_out, (div >= 2 && cnt < div / 2));
            end
            if (err !== m_err) begin
                n_bad++;
                $display("FAIL %s err got %b exp %b", ERR_TAG, err, m_err);
            end
        end
    end

endmodule

module clkdiv_top_test;
    import clkdiv_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'h0;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    logic [31:0] rd   [6];
    logic        tk   [6];
    logic        co   [6];
    logic        er   [6];
    int          rc   [6];
    int          rb   [6];

    clkdiv_top #(.MODE(DM_PLUS_ONE), .MASKED(1'b1)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[0]), .tick(tk[0]), .clk_out(co[0]), .err(er[0]));
    clkdiv_top #(.MODE(DM_ONE_BASED)) uut_ob (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[1]), .tick(tk[1]), .clk_out(co[1]), .err(er[1]));
    clkdiv_top #(.MODE(DM_ZERO_BYPASS)) uut_bz (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[2]), .tick(tk[2]), .clk_out(co[2]), .err(er[2]));
    clkdiv_top #(.MODE(DM_POW2)) uut_p2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[3]), .tick(tk[3]), .clk_out(co[3]), .err(er[3]));
    clkdiv_top #(.MODE(DM_MAX_AT_ZERO)) uut_mz (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[4]), .tick(tk[4]), .clk_out(co[4]), .err(er[4]));
    clkdiv_top #(.MODE(DM_PLUS_ONE), .READ_ONLY(1'b1)) uut_ro (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[5]), .tick(tk[5]), .clk_out(co[5]), .err(er[5]));

    clkdiv_ref #(.MODE(DM_PLUS_ONE), .MASKED(1'b1), .DIV_TAG("R1"), .WR_TAG("R8")) ref0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[0]),
        .tick(tk[0]), .clk_out(co[0]), .err(er[0]), .n_chk(rc[0]), .n_bad(rb[0]));
    clkdiv_ref #(.MODE(DM_ONE_BASED), .DIV_TAG("R2"), .ERR_TAG("R2")) ref1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[1]),
        .tick(tk[1]), .clk_out(co[1]), .err(er[1]), .n_chk(rc[1]), .n_bad(rb[1]));
    clkdiv_ref #(.MODE(DM_ZERO_BYPASS), .DIV_TAG("R3")) ref2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[2]),
        .tick(tk[2]), .clk_out(co[2]), .err(er[2]), .n_chk(rc[2]), .n_bad(rb[2]));
    clkdiv_ref #(.MODE(DM_POW2), .DIV_TAG("R4")) ref3 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[3]),
        .tick(tk[3]), .clk_out(co[3]), .err(er[3]), .n_chk(rc[3]), .n_bad(rb[3]));
    clkdiv_ref #(.MODE(DM_MAX_AT_ZERO), .DIV_TAG("R5")) ref4 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[4]),
        .tick(tk[4]), .clk_out(co[4]), .err(er[4]), .n_chk(rc[4]), .n_bad(rb[4]));
    clkdiv_ref #(.MODE(DM_PLUS_ONE), .RO(1'b1), .DIV_TAG("R1"), .WR_TAG("R10")) ref5 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[5]),
        .tick(tk[5]), .clk_out(co[5]), .err(er[5]), .n_chk(rc[5]), .n_bad(rb[5]));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 32'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        int tr, tf;
        tr = n_run;
        tf = n_fail;
        for (int i = 0; i < 6; i++) begin
            tr += rc[i];
            tf += rb[i];
        end
        $display("[TB] %0d tests run, %0d failed", tr, tf);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        check("R12 reset word", rd[0], 32'h30);
        check("R12 tick after reset", 32'(tk[0]), 32'd1);
        check("R12 err after reset", 32'(er[1]), 32'd0);
        idle(40);

        // field 5 with mask on bits 7:4
        write_word(32'h00F0_0050);
        #5;
        check("R8 masked store", rd[0], 32'h0000_0050);
        check("R9 full store", rd[1], 32'h00F0_0050);
        check("R10 read-only", rd[5], 32'h30);
        idle(80);

        // field 0: illegal in raw encoding, pass-through in bypass encoding
        write_word(32'h00F0_0000);
        idle(20);
        #5;
        check("R2 err set", 32'(er[1]), 32'd1);
        check("R2 output low", 32'(co[1]), 32'd0);
        @(posedge clk);
        #5;
        check("R3 clk_out high phase", 32'(co[2]), 32'd1);
        check("R3 tick every cycle", 32'(tk[2]), 32'd1);
        @(negedge clk);
        #5;
        check("R3 clk_out low phase", 32'(co[2]), 32'd0);
        idle(40);

        // empty mask: masked instance must not move
        write_word(32'h0000_00A0);
        #5;
        check("R8 empty mask", rd[0], 32'h0000_0000);
        idle(30);
        #5;
        check("R11 err stays", 32'(er[1]), 32'd1);
        idle(2100);

        // mid-period change of length
        write_word(32'h00F0_0020);
        idle(3);
        write_word(32'h00F0_0070);
        idle(200);

        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        #5;
        check("R11 err cleared by reset", 32'(er[1]), 32'd0);
        check("R12 reset word again", rd[1], 32'h30);
        idle(40);

        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

endmodule